// File: doc/BRIEF.md
# Cache-Aware Operating Mode Selector

This block chooses how a reconfigurable first-level cache and its supply run for the next stretch of execution. It has three choices. Normal mode keeps full capacity. High-speed mode merges pairs of lines, which halves capacity and cuts hit latency by one cycle. Dependable low-power mode also merges lines, and its payoff is a lower voltage at which the cache still works reliably. A free-running timer splits time into fixed evaluation periods. During each period four saturating counters tally single-cycle event pulses: retired instructions, retired loads and stores, cache misses, and extra misses. An extra miss is a hit that a half-sized cache would have missed.

When a period closes, the block decides the next mode from that period's totals and from the threshold and penalty inputs present at that edge. The first test checks whether the miss rate per thousand instructions is above the threshold. To avoid a divider, this test cross-multiplies with integer arithmetic. When the rate is above the threshold, the block picks low-power mode. Otherwise it forms a signed estimate: the cycles lost to reduced capacity minus the cycles saved by the faster hit path. It picks high-speed mode only when this estimate is negative. The chosen mode is registered, and a strobe marks each edge where the mode actually changes. The voltage and clock generation and the cache arrays are outside this block.

Top module: `cache_mode_governor`

## Requirements
- R1: While reset is asserted and right after it is released, `mode` is 2'b00 (normal) and `mode_change` is 0.
- R2: `mode` changes only on the period-closing edge. That edge is the PERIOD_CYCLES-th rising edge after reset release, and then every PERIOD_CYCLES rising edges after it.
- R3: On the closing edge, if miss_count × 1000 > threshold × instruction_count (unsigned, no truncation), then `mode` becomes 2'b10 (low-power), whatever the overhead estimate is. When the two sides are equal, this test does not select low-power.
- R4: If R3 does not apply and the overhead (cost minus benefit) is negative, `mode` becomes 2'b01 (high-speed).
- R5: If R3 does not apply and the overhead is zero or positive, `mode` becomes 2'b00 (normal).
- R6: Cost is extra_miss_count × `miss_penalty`. Benefit is load_store_count × 1 cycle of latency saving.
- R7: The four counters restart on the closing edge. An event pulse present on that edge is counted in the new period, and the old totals are used for the decision.
- R8: `mode_change` is high for exactly the one cycle after a closing edge that gave `mode` a new value. It is low at all other times, including after a closing edge that keeps the same mode.
- R9: Each event counter stops at 2^CNT_W−1 and does not wrap.
- R10: Cost and benefit are each clamped to 2^(OVH_W−1)−1 before the subtraction, so the overhead never wraps.
- R11: `mpki_limit` and `miss_penalty` are read only at the closing edge. Their values at any other time do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_evt | input | 1 | One retired instruction this cycle |
| lsu_evt | input | 1 | One retired load or store this cycle |
| miss_evt | input | 1 | One cache miss this cycle |
| xmiss_evt | input | 1 | One hit that a half-capacity cache would have missed |
| mpki_limit | input | THR_W | Miss-per-thousand-instructions threshold |
| miss_penalty | input | PEN_W | Miss penalty in cycles |
| mode | output | 2 | Current mode: 00 normal, 01 high-speed, 10 low-power |
| mode_change | output | 1 | One-cycle strobe when `mode` takes a new value |

## Verification
Several kinds of period are tried, and each one separates a different part of the decision.
- An exact tie on the miss-rate compare shows that the compare is strict.
- A period with a high miss rate and also a large load/store count shows that the miss-rate test takes priority over the overhead estimate.
- Periods where cost equals benefit, or benefit alone is present, separate the zero case from the negative case of the overhead sign.
- A period with instruction pulses on nearly every cycle pushes the counter into saturation. The saturated count flips the miss-rate outcome, while an unsaturated count would not.
- Random periods vary the event density and change the threshold and penalty on every cycle. These show that pulses on the closing edge go into the next period and that only the edge values of the threshold and penalty count. Repeated identical decisions show that the strobe stays low when the mode is unchanged.

// File: rtl/cmode_pkg.sv
package cmode_pkg;

    typedef enum logic [1:0] {
        MODE_FULL = 2'b00,
        MODE_FAST = 2'b01,
        MODE_SAFE = 2'b10
    } op_mode_e;

    typedef struct packed {
        op_mode_e mode;
        logic     chg;
    } mode_reg_t;

    localparam int N_EVT   = 4;
    localparam int EVT_INS = 0;
    localparam int EVT_LSU = 1;
    localparam int EVT_MIS = 2;
    localparam int EVT_XMS = 3;

endpackage

// File: rtl/cmode_period_timer.sv
module cmode_period_timer #(
    parameter int PERIOD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_end
);
    localparam int TMR_W = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(PERIOD_CYCLES - 1);

    logic [TMR_W-1:0] tmr_d, tmr_q;

    assign period_end = (tmr_q == LAST);

    always_comb begin
        tmr_d = period_end ? '0 : tmr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2: the timer restarts after every closing edge and never runs past the last count
    assert_timer_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (tmr_q == '0));
    assert_timer_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= LAST);

endmodule

// File: rtl/cmode_event_counter.sv
module cmode_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             evt,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear)                          cnt_d = CNT_W'(evt);
        else if (evt && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
        else                                cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R9: outside a restart the count never goes down, so it cannot wrap
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (cnt_q >= $past(cnt_q)));
    // R7: after a restart the count holds only the pulse seen on the closing edge
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == CNT_W'($past(evt))));

endmodule

// File: rtl/cmode_decider.sv
module cmode_decider
    import cmode_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int THR_W    = 8,
    parameter int PEN_W    = 10,
    parameter int OVH_W    = 24,
    parameter int LAT_SAVE = 1
) (
    input  logic [CNT_W-1:0] ins_cnt,
    input  logic [CNT_W-1:0] lsu_cnt,
    input  logic [CNT_W-1:0] mis_cnt,
    input  logic [CNT_W-1:0] xms_cnt,
    input  logic [THR_W-1:0] limit,
    input  logic [PEN_W-1:0] penalty,
    output logic             rate_hit,
    output logic             fast_win,
    output op_mode_e         pick
);
    localparam int MILLE_W = 10;
    localparam int L_W     = CNT_W + MILLE_W;
    localparam int R_W     = CNT_W + THR_W;
    localparam int CMP_W   = ((L_W > R_W) ? L_W : R_W) + 1;
    localparam int COST_W  = CNT_W + PEN_W;
    localparam int BEN_W   = CNT_W + $clog2(LAT_SAVE + 1);
    localparam int RAW_W   = (COST_W > BEN_W) ? COST_W : BEN_W;
    localparam int WIDE_W  = ((RAW_W > OVH_W) ? RAW_W : OVH_W) + 1;
    localparam int CAP     = (2 ** (OVH_W - 1)) - 1;

    logic [CMP_W-1:0]        lhs, rhs;
    logic [WIDE_W-1:0]       cost_raw, ben_raw;
    logic [OVH_W-2:0]        cost_sat, ben_sat;
    logic signed [OVH_W-1:0] overhead;

    always_comb begin
        lhs = CMP_W'(mis_cnt) * CMP_W'(1000);
        rhs = CMP_W'(limit) * CMP_W'(ins_cnt);
        rate_hit = (lhs > rhs);

        cost_raw = WIDE_W'(xms_cnt) * WIDE_W'(penalty);
        ben_raw  = WIDE_W'(lsu_cnt) * WIDE_W'(LAT_SAVE);
        cost_sat = (cost_raw > WIDE_W'(CAP)) ? (OVH_W-1)'(CAP) : cost_raw[OVH_W-2:0];
        ben_sat  = (ben_raw  > WIDE_W'(CAP)) ? (OVH_W-1)'(CAP) : ben_raw[OVH_W-2:0];
        overhead = $signed({1'b0, cost_sat}) - $signed({1'b0, ben_sat});
        fast_win = overhead[OVH_W-1];

        if (rate_hit)      pick = MODE_SAFE;
        else if (fast_win) pick = MODE_FAST;
        else               pick = MODE_FULL;
    end

endmodule

// File: rtl/cache_mode_governor.sv
module cache_mode_governor
    import cmode_pkg::*;
#(
    parameter int PERIOD_CYCLES = 1024,
    parameter int CNT_W         = 16,
    parameter int THR_W         = 8,
    parameter int PEN_W         = 10,
    parameter int OVH_W         = 24,
    parameter int LAT_SAVE      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_evt,
    input  logic             lsu_evt,
    input  logic             miss_evt,
    input  logic             xmiss_evt,
    input  logic [THR_W-1:0] mpki_limit,
    input  logic [PEN_W-1:0] miss_penalty,
    output logic [1:0]       mode,
    output logic             mode_change
);
    logic             period_end;
    logic [N_EVT-1:0] evt_vec;
    logic [CNT_W-1:0] cnt [N_EVT];
    logic             rate_hit, fast_win;
    op_mode_e         pick;
    mode_reg_t        st_d, st_q;

    assign evt_vec[EVT_INS] = inst_evt;
    assign evt_vec[EVT_LSU] = lsu_evt;
    assign evt_vec[EVT_MIS] = miss_evt;
    assign evt_vec[EVT_XMS] = xmiss_evt;

    cmode_period_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .period_end(period_end)
    );

    for (genvar g = 0; g < N_EVT; g++) begin : g_cnt
        cmode_event_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clear(period_end),
            .evt(evt_vec[g]), .count(cnt[g])
        );
    end

    cmode_decider #(
        .CNT_W(CNT_W), .THR_W(THR_W), .PEN_W(PEN_W),
        .OVH_W(OVH_W), .LAT_SAVE(LAT_SAVE)
    ) u_decide (
        .ins_cnt(cnt[EVT_INS]), .lsu_cnt(cnt[EVT_LSU]),
        .mis_cnt(cnt[EVT_MIS]), .xms_cnt(cnt[EVT_XMS]),
        .limit(mpki_limit), .penalty(miss_penalty),
        .rate_hit(rate_hit), .fast_win(fast_win), .pick(pick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (period_end) begin
            st_d.mode = pick;
            st_d.chg  = (pick != st_q.mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_FULL, chg: 1'b0};
        else        st_q <= st_d;
    end

    assign mode        = st_q.mode;
    assign mode_change = st_q.chg;

    // R2: the mode stays put between closing edges
    assert_hold_mid_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(mode));
    // R3: a miss-rate hit at the closing edge leads to low-power
    assert_rate_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && rate_hit) |=> (mode == MODE_SAFE));
    // R4: a negative overhead without a miss-rate hit leads to high-speed
    assert_fast_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !rate_hit && fast_win) |=> (mode == MODE_FAST));
    // R5: a non-negative overhead without a miss-rate hit leads to normal
    assert_full_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !rate_hit && !fast_win) |=> (mode == MODE_FULL));
    // R8: a new mode value always comes with the strobe, and the strobe lasts one cycle
    assert_strobe_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> mode_change);
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |=> !mode_change);
    // R1: the mode code is always one of the three legal values
    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

endmodule

// File: tb/cache_mode_governor_test.sv
module cache_mode_governor_test;
    localparam int P    = 100;
    localparam int CW   = 6;
    localparam int TW   = 8;
    localparam int PW   = 10;
    localparam int OW   = 12;
    localparam int MAXC = (1 << CW) - 1;
    localparam int CAP  = (1 << (OW - 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_ins = 1'b0, ev_lsu = 1'b0, ev_mis = 1'b0, ev_xms = 1'b0;
    logic [TW-1:0] thr = '0;
    logic [PW-1:0] pen = '0;
    logic [1:0]    mode;
    logic          mode_change;

    int n_tests = 0, n_fail = 0;
    int pos = 0;
    int a_ins = 0, a_lsu = 0, a_mis = 0, a_xms = 0;
    logic [1:0] exp_mode = 2'b00;
    bit    exp_chg = 1'b0;
    bit    done = 1'b0;
    string why = "R1 reset";

    always #4 clk = ~clk;

    cache_mode_governor #(
        .PERIOD_CYCLES(P), .CNT_W(CW), .THR_W(TW), .PEN_W(PW), .OVH_W(OW), .LAT_SAVE(1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .inst_evt(ev_ins), .lsu_evt(ev_lsu),
        .miss_evt(ev_mis), .xmiss_evt(ev_xms), .mpki_limit(thr),
        .miss_penalty(pen), .mode(mode), .mode_change(mode_change)
    );

    function automatic int sat(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    function automatic int clampc(input longint v);
        return (v > CAP) ? CAP : int'(v);
    endfunction

    // reference decision from the requirements (R3, R4, R5, R6, R10)
    function automatic logic [1:0] ref_pick(input int ni, nl, nm, nx, lim, pn);
        longint lhs, rhs;
        int cost, ben;
        lhs = longint'(nm) * 1000;
        rhs = longint'(lim) * ni;
        if (lhs > rhs) return 2'b10;
        cost = clampc(longint'(nx) * pn);
        ben  = clampc(longint'(nl));
        return (cost - ben < 0) ? 2'b01 : 2'b00;
    endfunction

    task automatic check_out();
        n_tests++;
        if (mode !== exp_mode || mode_change !== exp_chg) begin
            n_fail++;
            $display("FAIL %s: mode=%b chg=%b expected mode=%b chg=%b",
                     why, mode, mode_change, exp_mode, exp_chg);
        end
    endtask

    // at a falling edge: check, drive, and model the coming rising edge
    task automatic step(input bit i, input bit l, input bit m, input bit x, input string lbl);
        logic [1:0] nm;
        check_out();
        ev_ins = i; ev_lsu = l; ev_mis = m; ev_xms = x;
        if (pos == P - 1) begin
            nm = ref_pick(a_ins, a_lsu, a_mis, a_xms, int'(thr), int'(pen));
            exp_chg  = (nm != exp_mode);
            exp_mode = nm;
            why = $sformatf("%s %s", (nm == 2'b10) ? "R3 low-power" :
                            (nm == 2'b01) ? "R4 high-speed" : "R5 normal", lbl);
            a_ins = int'(i); a_lsu = int'(l); a_mis = int'(m); a_xms = int'(x);
            pos = 0;
        end else begin
            exp_chg = 1'b0;
            why = "R2 R8 hold";
            a_ins = sat(a_ins + int'(i)); a_lsu = sat(a_lsu + int'(l));
            a_mis = sat(a_mis + int'(m)); a_xms = sat(a_xms + int'(x));
            pos++;
        end
        @(negedge clk);
    endtask

    // directed period: n events of each kind in the first cycles, none on the closing edge
    task automatic dir_period(input int ni, nl, nm, nx, lim, pn, input string lbl);
        thr = TW'(lim);
        pen = PW'(pn);
        for (int c = 0; c < P; c++)
            step(c < ni, c < nl, c < nm, c < nx, lbl);
    endtask

    // random period: densities in percent, threshold and penalty move every cycle (R11, R7)
    task automatic rnd_period(input int di, dl, dm, dx);
        for (int c = 0; c < P; c++) begin
            thr = TW'($urandom_range(0, 255));
            pen = PW'($urandom_range(0, 1023));
            step($urandom_range(0, 99) < di, $urandom_range(0, 99) < dl,
                 $urandom_range(0, 99) < dm, $urandom_range(0, 99) < dx,
                 "R6 R7 R11 random");
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_out();
        rst_n = 1'b1;
        why = "R1 reset";
        // tie on the miss-rate compare: 1*1000 == 20*50, overhead 0 -> normal, no strobe
        dir_period(50, 0, 1, 0, 20, 0, "R3 tie R5 zero");
        // one more miss tips the compare -> low-power
        dir_period(50, 0, 2, 0, 20, 0, "R3 strict");
        // high miss rate beats a large benefit (R3 precedence)
        dir_period(60, 60, 30, 0, 10, 5, "R3 precedence");
        // benefit only -> high-speed (R6 benefit = load/store count)
        dir_period(60, 10, 0, 0, 10, 5, "R4 R6 benefit");
        // same decision again -> no strobe (R8)
        dir_period(60, 10, 0, 0, 10, 5, "R8 no repeat strobe");
        // cost equals benefit: 5*4 == 20 -> normal (R5, R6)
        dir_period(63, 20, 0, 5, 10, 4, "R5 R6 equal");
        // cost one below benefit -> high-speed
        dir_period(63, 20, 0, 19, 10, 1, "R4 R6 cost low");
        // instruction counter saturates at 63: 20000 > 255*63 only with saturation (R9)
        dir_period(99, 0, 20, 0, 255, 0, "R9 saturate");
        // cost clamps to CAP, still above benefit (R10)
        dir_period(63, 63, 0, 40, 255, 1023, "R10 clamp");
        for (int k = 0; k < 40; k++)
            rnd_period($urandom_range(20, 100), $urandom_range(0, 100),
                       $urandom_range(0, 15), $urandom_range(0, 10));
        step(1'b0, 1'b0, 1'b0, 1'b0, "R2 tail");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule